// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Three-Tap FIR

This block computes one output of a three-tap fixed-coefficient FIR filter without any multiplier. A start strobe captures three two's-complement samples into per-tap shift registers. The block then walks the sample bits from least significant upward, one bit position per cycle. On each step the current bit of every tap forms a three-bit address into a precomputed table, and each entry of that table is the sum of the coefficients whose address bit is set. The looked-up term is weighted by the power of two of its bit position and added into a signed accumulator. The most significant bit carries negative weight in two's complement, so the final step subtracts its weighted term. The finished sum is placed on the result port together with a one-cycle completion pulse.

The coefficient set is 2 for tap 0, 3 for tap 1 and 1 for tap 2, held in a shared package. The table can be built as plain logic or as a synchronous ROM with one cycle of read latency. Each lookup carries a small tag (valid, sign step, bit position) through the same pipeline stage as the table data, so the accumulator stays aligned in both variants. A job takes several cycles, and a start strobe is accepted only while the block is idle.

Top module: `da_fir3`

## Requirements
- R1: After a completion, result equals 2*s0 + 3*s1 + 1*s2, where s0, s1 and s2 are the values on smp0_in, smp1_in and smp2_in at the accepted start, each read as a W-bit two's-complement number.
- R2: The top bit of every sample has weight -2^(W-1), so negative samples give correctly signed results (for example s0=1, s1=-3, s2=7 gives 0, and s0=-1 with the others zero gives -2).
- R3: done rises exactly W+1 clock edges after the edge that accepts a start when ROM_REG=1, and exactly W edges after it when ROM_REG=0. result carries the new value in that same cycle.
- R4: done is high for exactly one cycle per accepted start, and it is never high without an accepted start.
- R5: result changes only in a cycle in which done is high. Between completions it holds its last value.
- R6: A start strobe while a job is in progress is ignored. It produces no extra done pulse, and the running job's result is unaffected.
- R7: While rst is high and in the cycle after it, done is 0 and result is 0. A start in the first cycle after reset is accepted.
- R8: Extreme inputs do not overflow. With all samples at -2^(W-1) the result is -6*2^(W-1), and with all samples at 2^(W-1)-1 it is 6*(2^(W-1)-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the three samples and begins a job when idle |
| smp0_in | input | W | Newest sample, coefficient 2 |
| smp1_in | input | W | Middle sample, coefficient 3 |
| smp2_in | input | W | Oldest sample, coefficient 1 |
| result | output | W+4 | Signed filter output, held between completions |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A completion is due W edges after the accepting edge with the logic table and W+1 edges after it with the registered table. The bench drives one instance of each variant from the same stimulus. When it issues a start, the driver records the expected value and the cycle number in which each instance's done must appear. The monitor samples on the falling edge, pops the oldest expected item when done is seen, and compares both the value and the arrival cycle. A done with an empty queue, or a result that moves without done, counts as a failure. The busy-ignore case injects a second strobe two cycles into a job, and the scoreboard then has to see exactly one completion with the first job's value.

// File: rtl/da_fir3_pkg.sv
package da_fir3_pkg;

    localparam int NTAP  = 3;
    localparam int POS_W = 4;

    localparam int unsigned COEF [NTAP] = '{2, 3, 1};

    function automatic int unsigned coef_total();
        int unsigned s;
        s = 0;
        for (int i = 0; i < NTAP; i++) s += COEF[i];
        return s;
    endfunction

    localparam int unsigned CSUM   = coef_total();
    localparam int          TERM_W = $clog2(CSUM + 1);

    typedef logic [NTAP-1:0] da_addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_SIGN,
        ST_DONE
    } da_state_t;

    typedef struct packed {
        logic             vld;
        logic             sgn;
        logic [POS_W-1:0] pos;
    } da_tag_t;

    function automatic logic [TERM_W-1:0] table_term(da_addr_t a);
        int unsigned s;
        s = 0;
        for (int i = 0; i < NTAP; i++)
            if (a[i]) s += COEF[i];
        return TERM_W'(s);
    endfunction

endpackage

// File: rtl/da_fir3_taps.sv
module da_fir3_taps
    import da_fir3_pkg::*;
#(
    parameter int W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     shift,
    input  logic [NTAP-1:0][W-1:0]   smp,
    output da_addr_t                 addr
);

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        logic [W-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst)        sr <= '0;
            else if (load)  sr <= smp[i];
            else if (shift) sr <= {1'b0, sr[W-1:1]};
        end
        assign addr[i] = sr[0];
    end

endmodule

// File: rtl/da_fir3_ctrl.sv
module da_fir3_ctrl
    import da_fir3_pkg::*;
#(
    parameter int W = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    done,
    output logic    idle,
    output logic    load,
    output logic    shift,
    output da_tag_t tag
);

    localparam int CW = $clog2(W);

    da_state_t       state;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_SHIFT;
                    cnt   <= '0;
                end
                ST_SHIFT: begin
                    if (cnt == CW'(W - 2)) state <= ST_SIGN;
                    else                   cnt   <= cnt + 1'b1;
                end
                ST_SIGN: state <= ST_DONE;
                ST_DONE: if (done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle    = (state == ST_IDLE);
        load    = idle && start;
        shift   = (state == ST_SHIFT);
        tag.vld = (state == ST_SHIFT) || (state == ST_SIGN);
        tag.sgn = (state == ST_SIGN);
        tag.pos = (state == ST_SIGN) ? POS_W'(W - 1) : POS_W'(cnt);
    end

endmodule

// File: rtl/da_fir3_rom.sv
module da_fir3_rom
    import da_fir3_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  da_addr_t          addr,
    input  da_tag_t           tag_in,
    output logic [TERM_W-1:0] term,
    output da_tag_t           tag_out
);

    logic [TERM_W-1:0] look;
    assign look = table_term(addr);

    if (REG_OUT) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                term    <= '0;
                tag_out <= '0;
            end else begin
                term    <= look;
                tag_out <= tag_in;
            end
        end
    end else begin : g_comb
        assign term    = look;
        assign tag_out = tag_in;
    end

endmodule

// File: rtl/da_fir3_acc.sv
module da_fir3_acc
    import da_fir3_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic [TERM_W-1:0]       term,
    input  da_tag_t                 tag,
    output logic signed [ACC_W-1:0] result,
    output logic                    done
);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] weighted;
    logic signed [ACC_W-1:0] acc_nxt;

    always_comb begin
        weighted = $signed(ACC_W'(term) << tag.pos);
        acc_nxt  = tag.sgn ? (acc - weighted) : (acc + weighted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                acc <= '0;
            end else if (tag.vld) begin
                acc <= acc_nxt;
                if (tag.sgn) begin
                    result <= acc_nxt;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/da_fir3.sv
module da_fir3
    import da_fir3_pkg::*;
#(
    parameter int W       = 4,
    parameter bit ROM_REG = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [W-1:0]              smp0_in,
    input  logic [W-1:0]              smp1_in,
    input  logic [W-1:0]              smp2_in,
    output logic signed [W+TERM_W:0]  result,
    output logic                      done
);

    localparam int ACC_W = W + TERM_W + 1;

    logic                   ctl_idle;
    logic                   ctl_load;
    logic                   ctl_shift;
    da_tag_t                tag_issue;
    da_tag_t                tag_late;
    da_addr_t               bit_addr;
    logic [TERM_W-1:0]      term;
    logic [NTAP-1:0][W-1:0] smp_bus;

    assign smp_bus = {smp2_in, smp1_in, smp0_in};

    da_fir3_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .done  (done),
        .idle  (ctl_idle),
        .load  (ctl_load),
        .shift (ctl_shift),
        .tag   (tag_issue)
    );

    da_fir3_taps #(.W(W)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl_load),
        .shift (ctl_shift),
        .smp   (smp_bus),
        .addr  (bit_addr)
    );

    da_fir3_rom #(.REG_OUT(ROM_REG)) u_rom (
        .clk     (clk),
        .rst     (rst),
        .addr    (bit_addr),
        .tag_in  (tag_issue),
        .term    (term),
        .tag_out (tag_late)
    );

    da_fir3_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl_load),
        .term   (term),
        .tag    (tag_late),
        .result (result),
        .done   (done)
    );

endmodule

// File: rtl/da_fir3_chk.sv
module da_fir3_chk
    import da_fir3_pkg::*;
#(
    parameter int W   = 4,
    parameter int LAT = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     idle,
    input logic                     done,
    input logic signed [W+TERM_W:0] result
);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                run_cnt <= 0;
        else if (done)          run_cnt <= 0;
        else if (start && idle) run_cnt <= 1;
        else if (run_cnt != 0)  run_cnt <= run_cnt + 1;
    end

    // R3 and R4: a pulse arrives only for an accepted job, on its due cycle
    a_r3_due_cycle: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == W + LAT + 1));

    // R4: the pulse lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: the output moves only together with the pulse
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R7: reset clears the outputs
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!done && result == '0));

endmodule

bind da_fir3 da_fir3_chk #(.W(W), .LAT(ROM_REG ? 1 : 0)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .idle   (ctl_idle),
    .done   (done),
    .result (result)
);

// File: tb/da_fir3_bench.sv
module da_fir3_bench;

    localparam int W = 4;

    typedef struct {
        int val;
        int due;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [W-1:0] smp0 = '0, smp1 = '0, smp2 = '0;
    logic signed [W+3:0] res_s, res_f;
    logic done_s, done_f;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit fin = 1'b0;
    exp_t qs[$];
    exp_t qf[$];
    int last_s = 0, last_f = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    da_fir3 #(.W(W), .ROM_REG(1'b1)) u_da_fir3 (
        .clk(clk), .rst(rst), .start(start),
        .smp0_in(smp0), .smp1_in(smp1), .smp2_in(smp2),
        .result(res_s), .done(done_s)
    );

    da_fir3 #(.W(W), .ROM_REG(1'b0)) u_da_fir3_comb (
        .clk(clk), .rst(rst), .start(start),
        .smp0_in(smp0), .smp1_in(smp1), .smp2_in(smp2),
        .result(res_f), .done(done_f)
    );

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sx(logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    // monitor for the registered-table instance
    always @(negedge clk) begin
        if (!rst) begin
            if (done_s) begin
                if (qs.size() == 0) begin
                    check(1'b0, "R4/R6 sync unexpected done", int'(res_s), 0);
                end else begin
                    exp_t e;
                    e = qs.pop_front();
                    check(int'(res_s) == e.val, "R1 sync value", int'(res_s), e.val);
                    check(cyc == e.due, "R3 sync timing", cyc, e.due);
                end
            end else if (int'(res_s) != last_s) begin
                check(1'b0, "R5 sync hold", int'(res_s), last_s);
            end
            last_s = int'(res_s);
        end
    end

    // monitor for the logic-table instance
    always @(negedge clk) begin
        if (!rst) begin
            if (done_f) begin
                if (qf.size() == 0) begin
                    check(1'b0, "R4/R6 comb unexpected done", int'(res_f), 0);
                end else begin
                    exp_t e;
                    e = qf.pop_front();
                    check(int'(res_f) == e.val, "R1 comb value", int'(res_f), e.val);
                    check(cyc == e.due, "R3 comb timing", cyc, e.due);
                end
            end else if (int'(res_f) != last_f) begin
                check(1'b0, "R5 comb hold", int'(res_f), last_f);
            end
            last_f = int'(res_f);
        end
    end

    task automatic job(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, bit poke);
        int e;
        e = 2 * sx(a) + 3 * sx(b) + sx(c);
        smp0  <= a;
        smp1  <= b;
        smp2  <= c;
        start <= 1'b1;
        qs.push_back('{e, cyc + 1 + W + 1});
        qf.push_back('{e, cyc + 1 + W});
        @(negedge clk);
        start <= 1'b0;
        if (poke) begin
            // R6: a second strobe mid-job with different samples
            @(negedge clk);
            smp0  <= ~a;
            smp1  <= ~b;
            smp2  <= ~c;
            start <= 1'b1;
            @(negedge clk);
            start <= 1'b0;
        end
        wait (qs.size() == 0 && qf.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] lfsr;
        repeat (3) @(negedge clk);
        // R7: outputs cleared while in reset
        check(done_s == 1'b0 && done_f == 1'b0, "R7 done in reset", int'(done_s | done_f), 0);
        check(res_s == '0 && res_f == '0, "R7 result in reset", int'(res_s), 0);
        rst <= 1'b0;
        @(negedge clk);
        // R7: start in the first cycle after reset is accepted
        job(4'd1, 4'd3, 4'd7, 1'b0);             // R1: 18
        job(4'd1, 4'd0, 4'd0, 1'b0);             // R1: tap 0 weight 2
        job(4'd0, 4'd1, 4'd0, 1'b0);             // R1: tap 1 weight 3
        job(4'd0, 4'd0, 4'd1, 1'b0);             // R1: tap 2 weight 1
        job(4'd0, 4'd0, 4'd0, 1'b0);             // R1: zero
        job(4'd1, 4'b1101, 4'd7, 1'b0);          // R2: 1,-3,7 gives 0
        job(4'b1111, 4'd0, 4'd0, 1'b0);          // R2: -1 gives -2
        job(4'b1000, 4'b1000, 4'b1000, 1'b0);    // R8: -48
        job(4'd7, 4'd7, 4'd7, 1'b0);             // R8: 42
        job(4'd5, 4'b1010, 4'd2, 1'b1);          // R6: busy strobe ignored
        job(4'b1001, 4'd6, 4'b1100, 1'b1);       // R6
        lfsr = 12'hA5C;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
            job(lfsr[3:0], lfsr[7:4], lfsr[11:8], (i % 7) == 3);
        end
        repeat (5) @(negedge clk);
        // R4: every accepted job completed exactly once
        check(qs.size() == 0 && qf.size() == 0, "R4 pending jobs", qs.size() + qf.size(), 0);
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule